// File: doc/BRIEF.md
# Serial Memory Slave Command Interface

This block is the slave side of a three-wire serial memory port. The port has a chip select, a serial clock, a data input, and a data output with an enable. The block sits in front of a 256-word by 16-bit memory and four 16-bit converter registers, all held in a plain register array. It samples 16-bit instruction frames and decodes three commands:

- a streaming read, which serves the addressed word most significant bit first and then steps to the following words for as long as clocks arrive;
- a programming-enable command, which sets a latch that gates later write commands;
- a programming-disable command, which clears that latch.

The serial pins are asynchronous to the block clock. They pass through a synchronizer, and the block turns them into rising-edge and falling-edge events. While the output enable is low, the pad is treated as high impedance and the data output is held at 0. The storage is filled through a parallel preload port, which stands in for the programming path that lies outside this block.

Top module: `sm_serial_slave`

## Requirements
- R1: After reset, prog_en_o is 0, do_oe_o is 0 and do_o is 0.
- R2: While cs_i is high, di_i is sampled on each rising edge of sk_i, first bit first. A frame whose first seven bits are 1010100 is a read, and its last nine bits (frame bits 8..0) give the start address, most significant first.
- R3: After a read frame, do_oe_o stays low through the 16th falling edge and through the 17th rising edge of sk_i. It goes high after the 17th falling edge, and do_o then shows bit 15 of the addressed word.
- R4: Each later falling edge presents the next lower bit of the word. do_o is 0 whenever do_oe_o is low.
- R5: The falling edge after bit 0 presents bit 15 of the next word, with no limit on the number of words. In the memory region (address bit 8 = 0), only bits 7..0 advance, so 0x0FF is followed by 0x000.
- R6: In the converter region (address bit 8 = 1), register index = address bits 1..0. Only those bits advance, so 0x103 is followed by 0x100.
- R7: Frame bits 15..10 = 101000 with bits 9..8 = 11 set prog_en_o, and with bits 9..8 = 00 clear it. Bits 7..0 are ignored. Neither frame ever raises do_oe_o.
- R8: prog_en_o keeps its value until the next enable or disable frame, or until reset.
- R9: Read data and timing are the same whether prog_en_o is 0 or 1.
- R10: A low cs_i at any point drops do_oe_o within four clocks and discards a partly received frame. The next frame after cs_i rises again is decoded from its first bit.
- R11: A frame matching neither prefix, or carrying 10 or 01 in the command bits, changes neither prog_en_o nor do_oe_o.
- R12: A cycle with ld_en_i high writes ld_data_i to the word at ld_addr_i. Addresses 0x000..0x0FF are memory words; addresses with bit 8 set select converter register ld_addr_i[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, 0 while disabled |
| do_oe_o | output | 1 | Output enable of the data pad |
| prog_en_o | output | 1 | Programming-enable latch |
| ld_en_i | input | 1 | Preload write strobe |
| ld_addr_i | input | 9 | Preload word address |
| ld_data_i | input | 16 | Preload word data |

## Verification
The hardest state to reach from the pins is a frame cut off by chip select after ten bits, followed at once by a full read. A bit counter that failed to clear would misalign the second frame. The bench sends that truncated enable frame and then checks both the read data and the unchanged latch. Both region wraps need a stream of three consecutive words that starts two words below each boundary. The edge at which the output turns on is pinned by sampling the enable after the 16th falling edge, again after the 17th rising edge, and then after the 17th falling edge.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int FRAME_W = 16;
  localparam logic [6:0] RD_PFX = 7'b1010100;
  localparam logic [5:0] WC_PFX = 6'b101000;
  localparam logic [1:0] WC_EN  = 2'b11;
  localparam logic [1:0] WC_DIS = 2'b00;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WREN,
    CMD_WRDS
  } cmd_e;
endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[0] <= '0;
        else         ff_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= '0;
        else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sm_pin_front.sv
module sm_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] raw, synced;
  logic       sk_s, sk_d_q, rise_q, fall_q;

  assign raw = {cs_i, sk_i, di_i};

  sm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign sk_s = synced[1];

  // registered edge pulses keep di aligned one cycle behind its sample
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sk_d_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      cs_o   <= 1'b0;
      di_o   <= 1'b0;
    end else begin
      sk_d_q <= sk_s;
      rise_q <= sk_s & ~sk_d_q & synced[2];
      fall_q <= ~sk_s & sk_d_q & synced[2];
      cs_o   <= synced[2];
      di_o   <= synced[0];
    end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/sm_frame_rx.sv
module sm_frame_rx
  import sm_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rise_i,
  input  logic          di_i,
  output cmd_e          cmd_o,
  output logic [AW-1:0] addr_o
);
  localparam int FW = FRAME_W;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sh_q, frame_nxt;
  logic [CW-1:0] cnt_q;
  cmd_e          cmd_nxt;

  always_comb begin
    frame_nxt = {sh_q[FW-2:0], di_i};
    cmd_nxt   = CMD_NONE;
    if (frame_nxt[FW-1 -: 7] == RD_PFX)
      cmd_nxt = CMD_READ;
    else if (frame_nxt[FW-1 -: 6] == WC_PFX) begin
      if (frame_nxt[FW-7 -: 2] == WC_EN)       cmd_nxt = CMD_WREN;
      else if (frame_nxt[FW-7 -: 2] == WC_DIS) cmd_nxt = CMD_WRDS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      cmd_o  <= CMD_NONE;
      addr_o <= '0;
    end else if (!cs_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      cmd_o <= CMD_NONE;
    end else begin
      cmd_o <= CMD_NONE;
      if (rise_i && cnt_q < CW'(FW)) begin
        sh_q  <= frame_nxt;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(FW - 1)) begin
          cmd_o  <= cmd_nxt;
          addr_o <= frame_nxt[AW-1:0];
        end
      end
    end
endmodule

// File: rtl/sm_reader.sv
module sm_reader
  import sm_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int CAW    = 2,
  parameter int DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              fall_i,
  input  cmd_e              cmd_i,
  input  logic [MEM_AW:0]   addr_i,
  output logic [MEM_AW:0]   rd_addr_o,
  input  logic [DW-1:0]     rd_data_i,
  output logic              do_o,
  output logic              oe_o
);
  localparam int AW = MEM_AW + 1;
  localparam int BW = $clog2(DW);

  logic          active_q, skip_q, oe_q, do_q;
  logic [AW-1:0] addr_q, nxt_addr;
  logic [DW-1:0] sh_q;
  logic [BW-1:0] bit_q;

  // each region wraps on its own low bits
  always_comb begin
    if (addr_q[AW-1])
      nxt_addr = {addr_q[AW-1:CAW], addr_q[CAW-1:0] + CAW'(1)};
    else
      nxt_addr = {1'b0, addr_q[MEM_AW-1:0] + MEM_AW'(1)};
  end

  assign rd_addr_o = (cmd_i == CMD_READ) ? addr_i : nxt_addr;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      active_q <= 1'b0;
      skip_q   <= 1'b0;
      oe_q     <= 1'b0;
      do_q     <= 1'b0;
      addr_q   <= '0;
      sh_q     <= '0;
      bit_q    <= '0;
    end else if (!cs_i) begin
      active_q <= 1'b0;
      skip_q   <= 1'b0;
      oe_q     <= 1'b0;
      do_q     <= 1'b0;
    end else if (cmd_i == CMD_READ) begin
      active_q <= 1'b1;
      skip_q   <= 1'b1;  // 16th falling edge still belongs to the frame
      addr_q   <= addr_i;
      sh_q     <= rd_data_i;
      bit_q    <= '0;
    end else if (active_q && fall_i) begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else begin
        oe_q <= 1'b1;
        do_q <= sh_q[DW-1];
        if (bit_q == BW'(DW - 1)) begin
          addr_q <= nxt_addr;
          sh_q   <= rd_data_i;
          bit_q  <= '0;
        end else begin
          sh_q  <= {sh_q[DW-2:0], 1'b0};
          bit_q <= bit_q + BW'(1);
        end
      end
    end

  assign do_o = do_q;
  assign oe_o = oe_q;
endmodule

// File: rtl/sm_store.sv
module sm_store #(
  parameter int MEM_AW = 8,
  parameter int N_CONV = 4,
  parameter int DW     = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [MEM_AW:0] waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [MEM_AW:0] raddr_i,
  output logic [DW-1:0]   rdata_o
);
  localparam int AW    = MEM_AW + 1;
  localparam int WORDS = 2 ** MEM_AW;
  localparam int CAW   = $clog2(N_CONV);

  logic [DW-1:0] mem_q  [WORDS];
  logic [DW-1:0] conv_q [N_CONV];

  always_ff @(posedge clk_i)
    if (we_i && !waddr_i[AW-1]) mem_q[waddr_i[MEM_AW-1:0]] <= wdata_i;

  for (genvar g = 0; g < N_CONV; g++) begin : g_conv
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) conv_q[g] <= '0;
      else if (we_i && waddr_i[AW-1] && waddr_i[CAW-1:0] == CAW'(g))
        conv_q[g] <= wdata_i;
  end

  assign rdata_o = raddr_i[AW-1] ? conv_q[raddr_i[CAW-1:0]]
                                 : mem_q[raddr_i[MEM_AW-1:0]];
endmodule

// File: rtl/sm_serial_slave.sv
module sm_serial_slave
  import sm_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int N_CONV      = 4,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_i,
  input  logic            sk_i,
  input  logic            di_i,
  output logic            do_o,
  output logic            do_oe_o,
  output logic            prog_en_o,
  input  logic            ld_en_i,
  input  logic [MEM_AW:0] ld_addr_i,
  input  logic [DW-1:0]   ld_data_i
);
  localparam int AW  = MEM_AW + 1;
  localparam int CAW = $clog2(N_CONV);

  logic          cs_s, di_s, sk_rise, sk_fall;
  cmd_e          cmd;
  logic [AW-1:0] frm_addr, rd_addr;
  logic [DW-1:0] rd_data;
  logic          prog_en_q;

  sm_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs_i),
    .sk_i  (sk_i),
    .di_i  (di_i),
    .cs_o  (cs_s),
    .di_o  (di_s),
    .rise_o(sk_rise),
    .fall_o(sk_fall)
  );

  sm_frame_rx #(.AW(AW)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs_s),
    .rise_i(sk_rise),
    .di_i  (di_s),
    .cmd_o (cmd),
    .addr_o(frm_addr)
  );

  sm_reader #(.MEM_AW(MEM_AW), .CAW(CAW), .DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_s),
    .fall_i   (sk_fall),
    .cmd_i    (cmd),
    .addr_i   (frm_addr),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data),
    .do_o     (do_o),
    .oe_o     (do_oe_o)
  );

  sm_store #(.MEM_AW(MEM_AW), .N_CONV(N_CONV), .DW(DW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ld_en_i),
    .waddr_i(ld_addr_i),
    .wdata_i(ld_data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                prog_en_q <= 1'b0;
    else if (cmd == CMD_WREN)   prog_en_q <= 1'b1;
    else if (cmd == CMD_WRDS)   prog_en_q <= 1'b0;

  assign prog_en_o = prog_en_q;
endmodule

// File: rtl/sm_serial_slave_chk.sv
module sm_serial_slave_chk
  import sm_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic sk_fall,
  input cmd_e cmd,
  input logic prog_en,
  input logic oe,
  input logic dout
);
  a_r10_cs_low_drops_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !oe);

  a_r3_no_drive_at_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_READ |=> !oe);

  a_r4_oe_follows_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe) |-> $past(sk_fall));

  a_r4_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe |-> !dout);

  a_r7_wren_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_WREN |=> prog_en);

  a_r7_wrds_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_WRDS |=> !prog_en);

  a_r8_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_WREN && cmd != CMD_WRDS) |=> prog_en == $past(prog_en));

  a_r11_cmd_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd != CMD_NONE |-> $past(cs_s));
endmodule

bind sm_serial_slave sm_serial_slave_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_s   (cs_s),
  .sk_fall(sk_fall),
  .cmd    (cmd),
  .prog_en(prog_en_o),
  .oe     (do_oe_o),
  .dout   (do_o)
);

// File: tb/tb_sm_serial_slave.sv
module tb_sm_serial_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic        do_w, oe_w, pe_w;
  logic        ld_en = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  sm_serial_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(oe_w), .prog_en_o(pe_w),
    .ld_en_i(ld_en), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  function automatic logic [15:0] exp_word(logic [8:0] a);
    if (a[8]) return {4'h9, 2'b00, a[1:0], 8'h3C};
    return {a[7:0] ^ 8'hA5, ~a[7:0]};
  endfunction

  function automatic logic [8:0] next_addr(logic [8:0] a);
    if (a[8]) return {a[8:2], a[1:0] + 2'd1};
    return {1'b0, a[7:0] + 8'd1};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    cs = 1'b1; sk = 1'b0; tick(HALF);
  endtask

  task automatic cs_off();
    cs = 1'b0; sk = 1'b0; tick(HALF);
  endtask

  task automatic send_bits(logic [15:0] f, int n);
    for (int i = 0; i < n; i++) begin
      di = f[15-i];
      tick(HALF);
      sk = 1'b1;
      tick(HALF);
      sk = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic read_word(bit first, output logic [15:0] w, output bit oe_all);
    oe_all = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sk = 1'b1;
      tick(HALF);
      if (first && i == 0) check("R3 oe low after 17th rise", oe_w, 0);
      sk = 1'b0;
      tick(HALF);
      w[15-i] = do_w;
      oe_all &= oe_w;
    end
  endtask

  // R2 R5 R6: frame then a stream of n words
  task automatic t_read(logic [8:0] a, int n, string req);
    logic [15:0] w;
    bit ok;
    logic [8:0] cur = a;
    cs_on();
    send_bits({7'b1010100, a}, 16);
    check({req, " R3 oe low after 16th fall"}, oe_w, 0);
    for (int k = 0; k < n; k++) begin
      read_word(k == 0, w, ok);
      check({req, " R4 data"}, w, exp_word(cur));
      check({req, " R3 oe high"}, ok, 1);
      cur = next_addr(cur);
    end
    cs_off();
    check({req, " R10 oe off"}, oe_w, 0);
  endtask

  task automatic t_reset();
    check("R1 oe", oe_w, 0);
    check("R1 do", do_w, 0);
    check("R1 prog_en", pe_w, 0);
  endtask

  task automatic t_preload();
    for (int a = 0; a < 256; a++) begin
      ld_en = 1'b1; ld_addr = 9'(a); ld_data = exp_word(9'(a)); tick(1);
    end
    for (int a = 256; a < 260; a++) begin
      ld_en = 1'b1; ld_addr = 9'(a); ld_data = exp_word(9'(a)); tick(1);
    end
    ld_en = 1'b0; tick(2);
  endtask

  task automatic t_wcmd(logic [1:0] op, logic [7:0] dc, logic exp_pe, string req);
    logic [15:0] w;
    bit ok;
    cs_on();
    send_bits({6'b101000, op, dc}, 16);
    check({req, " prog_en"}, pe_w, exp_pe);
    read_word(1'b0, w, ok);
    check("R7 no drive after command", oe_w, 0);
    cs_off();
  endtask

  task automatic t_unknown(logic [15:0] f);
    logic [15:0] w;
    bit ok;
    logic pe0 = pe_w;
    cs_on();
    send_bits(f, 16);
    read_word(1'b0, w, ok);
    check("R11 oe stays low", oe_w, 0);
    cs_off();
    check("R11 prog_en unchanged", pe_w, pe0);
  endtask

  task automatic t_abort();
    logic [15:0] w;
    bit ok;
    cs_on();
    send_bits({7'b1010100, 9'h020}, 16);
    for (int i = 0; i < 5; i++) begin
      sk = 1'b1; tick(HALF); sk = 1'b0; tick(HALF);
    end
    check("R10 oe on mid-word", oe_w, 1);
    cs = 1'b0; sk = 1'b0; tick(4);
    check("R10 oe off within 4 clocks", oe_w, 0);
    tick(HALF);
    // truncated enable frame, then a full read
    cs_on();
    send_bits({6'b101000, 2'b11, 8'h00}, 10);
    cs_off();
    cs_on();
    send_bits({7'b1010100, 9'h030}, 16);
    read_word(1'b0, w, ok);
    check("R10 fresh frame data", w, exp_word(9'h030));
    check("R10 fresh frame oe", ok, 1);
    cs_off();
    check("R10 truncated frame ignored", pe_w, 0);
  endtask

  task automatic t_conv_reload();
    ld_en = 1'b1; ld_addr = 9'h101; ld_data = 16'hBEEF; tick(1);
    ld_en = 1'b0; tick(2);
    cs_on();
    begin
      logic [15:0] w;
      bit ok;
      send_bits({7'b1010100, 9'h101}, 16);
      read_word(1'b1, w, ok);
      check("R12 converter reload", w, 16'hBEEF);
    end
    cs_off();
    ld_en = 1'b1; ld_data = exp_word(9'h101); tick(1);
    ld_en = 1'b0; tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_preload();
    t_read(9'h010, 2, "R2");
    t_read(9'h0FE, 3, "R5 wrap");
    t_read(9'h102, 3, "R6 wrap");
    t_read(9'h1FF, 2, "R6 alias");
    t_wcmd(2'b11, 8'h5A, 1'b1, "R7 enable");
    t_read(9'h0A5, 2, "R9 enabled");
    t_unknown(16'hFFFF);
    t_unknown({6'b101000, 2'b10, 8'h00});
    t_unknown({7'b1010101, 9'h010});
    check("R8 latch held", pe_w, 1);
    t_wcmd(2'b00, 8'hC3, 1'b0, "R7 disable");
    t_unknown({6'b101000, 2'b01, 8'hFF});
    check("R8 latch stays clear", pe_w, 0);
    t_abort();
    t_conv_reload();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule